// File: doc/BRIEF.md
# Supply Start-Up and Adaptive Undervoltage Supervisor

This block sequences the supply of a switching controller from digitized comparisons of its own supply voltage. While the supply is below the turn-on level, it enables a high-voltage start-up current source, but only when the input bus is present. Once the turn-on level is reached, it turns the source off and asserts both supply-OK and run. Run drops when the supply sags below the active undervoltage-lockout (UVLO) level. Supply-OK is held until the supply falls below a much lower restart level, and only then does the block return to charging.

The UVLO level adapts to the load. A light-load flag selects a reduced turn-off level, so that the supply can droop during low-power operation without stopping the chip. The normal level comes back only when the load flag has cleared and the supply is again above the normal level.

When a latched fault is reported while running, the block enters a keep-alive mode. Run stays off and supply-OK stays on. The start-up source recharges the supply whenever it falls below the "turn-on minus one" level and stops at the turn-on level, which keeps the latch powered. The keep-alive mode ends when the fault flag is released. The block then drains to the restart level like a normal shutdown.

Top module: `vsup_top`

## Requirements
- R1: After a synchronous active-low reset, the block is in the charging state: run=0, supply_ok=0, uvlo_low_sel=0 (the normal level), and hv_src_en equals bus_ok.
- R2: In the charging state, hv_src_en follows bus_ok. When vcc_ge_on=1, one clock later run=1, supply_ok=1 and hv_src_en=0.
- R3: While running, if the comparison against the active UVLO level reads 0, run goes to 0 one clock later. That comparison is vcc_ge_off_red when uvlo_low_sel=1 and vcc_ge_off_nom otherwise. supply_ok stays 1 and hv_src_en stays 0 until vcc_ge_restart=0.
- R4: In the drained state, vcc_ge_restart=0 returns the block to charging one clock later with supply_ok=0. hv_src_en is then 1 only if bus_ok=1.
- R5: light_load=1 sets uvlo_low_sel to 1 one clock later, in any state.
- R6: uvlo_low_sel returns to 0 one clock after a cycle in which light_load=0 and vcc_ge_off_nom=1. If either condition is missing, it stays 1.
- R7: fault_held=1 while running moves the block, one clock later, to keep-alive hold: run=0, supply_ok=1, hv_src_en=0. In hold, vcc_ge_on_m1=0 starts recharging (hv_src_en=bus_ok), and recharging continues until vcc_ge_on=1 returns it to hold.
- R8: fault_held=0 in either keep-alive state moves the block, one clock later, to the drained state (run=0, supply_ok=1, hv_src_en=0).
- R9: hv_src_en and run are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ok | input | 1 | Input bus above its start level |
| light_load | input | 1 | Control level below the light-load level (hysteresis applied upstream) |
| fault_held | input | 1 | A latched fault is being held |
| vcc_ge_on | input | 1 | Supply at or above the turn-on level |
| vcc_ge_on_m1 | input | 1 | Supply at or above turn-on minus one unit |
| vcc_ge_off_nom | input | 1 | Supply at or above the normal UVLO level |
| vcc_ge_off_red | input | 1 | Supply at or above the reduced UVLO level |
| vcc_ge_restart | input | 1 | Supply at or above the restart level |
| hv_src_en | output | 1 | Start-up current source enable |
| supply_ok | output | 1 | Supply-OK |
| run | output | 1 | Chip run enable |
| uvlo_low_sel | output | 1 | 1 = reduced UVLO level selected, 0 = normal |

## Verification
The main sequence is walked through four patterns, each on its own supply ramp. A plain power-up and power-down shows whether the restart level, not the UVLO level, ends supply-OK. A load swing in which the supply sits between the reduced and normal levels separates a correct selector from one that restores the normal level on the load flag alone. Dropping the bus before the restart level confirms that the source stays off at power-down. A fault sequence with the supply between the two upper levels tells a correct keep-alive hysteresis from one that recharges too early or stops too late.

// File: rtl/vsup_pkg.sv
// Package: shared state encoding for the supply supervisor.
// Assumes all users compile this file first.
package vsup_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_CHARGE  = 3'd0,  // source may charge, chip held off
        ST_RUN     = 3'd1,  // chip running, source off
        ST_DRAIN   = 3'd2,  // chip stopped, waiting for the restart level
        ST_KA_HOLD = 3'd3,  // fault held, waiting for supply to sag
        ST_KA_CHG  = 3'd4   // fault held, recharging to turn-on
    } vsup_state_t;

endpackage

// File: rtl/vsup_uvlo_sel.sv
// Module: adaptive UVLO level selector.
// Selects the reduced turn-off level at light load. It restores the normal
// level only when light load has cleared and the supply is above the
// normal level. Assumes all inputs are synchronized single bits.
module vsup_uvlo_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic light_load,
    input  logic vcc_ge_off_nom,
    input  logic vcc_ge_off_red,
    output logic low_sel,
    output logic above_active
);

    // Register holding the selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_sel <= 1'b0;
        end else if (light_load) begin
            low_sel <= 1'b1;
        end else if (low_sel && vcc_ge_off_nom) begin
            low_sel <= 1'b0;
        end
    end

    // Comparison against whichever level is currently active.
    always_comb begin
        above_active = low_sel ? vcc_ge_off_red : vcc_ge_off_nom;
    end

    AST_LOW_ON_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        light_load |=> low_sel); // R5

    AST_NORMAL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (low_sel && (light_load || !vcc_ge_off_nom)) |=> low_sel); // R6

endmodule

// File: rtl/vsup_seq.sv
// Module: start-up / run / keep-alive sequencer.
// Holds the supervisor state and moves it on single-bit threshold
// comparisons. Assumes above_active already reflects the selected UVLO level.
module vsup_seq
    import vsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fault_held,
    input  logic        vcc_ge_on,
    input  logic        vcc_ge_on_m1,
    input  logic        vcc_ge_restart,
    input  logic        above_active,
    output vsup_state_t state
);

    vsup_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CHARGE:  if (vcc_ge_on) nxt = ST_RUN;
            ST_RUN: begin
                if (fault_held)         nxt = ST_KA_HOLD;
                else if (!above_active) nxt = ST_DRAIN;
            end
            ST_DRAIN:   if (!vcc_ge_restart) nxt = ST_CHARGE;
            ST_KA_HOLD: begin
                if (!fault_held)        nxt = ST_DRAIN;
                else if (!vcc_ge_on_m1) nxt = ST_KA_CHG;
            end
            ST_KA_CHG: begin
                if (!fault_held)        nxt = ST_DRAIN;
                else if (vcc_ge_on)     nxt = ST_KA_HOLD;
            end
            default:    nxt = ST_CHARGE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CHARGE;
        else        state <= nxt;
    end

    AST_RUN_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHARGE && !vcc_ge_on) |=> (state == ST_CHARGE)); // R2

    AST_DRAIN_TO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !vcc_ge_restart) |=> (state == ST_CHARGE)); // R4

endmodule

// File: rtl/vsup_outdec.sv
// Module: output decoder.
// Maps the sequencer state to source enable, supply-OK and run. Assumes the
// start-up source may only draw current while the input bus is present.
module vsup_outdec
    import vsup_pkg::*;
(
    input  vsup_state_t state,
    input  logic        bus_ok,
    output logic        hv_src_en,
    output logic        supply_ok,
    output logic        run
);

    // Decode outputs from state.
    always_comb begin
        hv_src_en = 1'b0;
        supply_ok = 1'b0;
        run       = 1'b0;
        unique case (state)
            ST_CHARGE:  hv_src_en = bus_ok;
            ST_RUN:     begin supply_ok = 1'b1; run = 1'b1; end
            ST_DRAIN:   supply_ok = 1'b1;
            ST_KA_HOLD: supply_ok = 1'b1;
            ST_KA_CHG:  begin supply_ok = 1'b1; hv_src_en = bus_ok; end
            default:    hv_src_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/vsup_top.sv
// Module: supply start-up and adaptive UVLO supervisor, top level.
// Combines the level selector, the sequencer and the output decoder.
// Assumes every comparator input is already synchronized to clk.
module vsup_top
    import vsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_ok,
    input  logic light_load,
    input  logic fault_held,
    input  logic vcc_ge_on,
    input  logic vcc_ge_on_m1,
    input  logic vcc_ge_off_nom,
    input  logic vcc_ge_off_red,
    input  logic vcc_ge_restart,
    output logic hv_src_en,
    output logic supply_ok,
    output logic run,
    output logic uvlo_low_sel
);

    vsup_state_t state;
    logic        above_active;

    vsup_uvlo_sel u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .light_load     (light_load),
        .vcc_ge_off_nom (vcc_ge_off_nom),
        .vcc_ge_off_red (vcc_ge_off_red),
        .low_sel        (uvlo_low_sel),
        .above_active   (above_active)
    );

    vsup_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault_held     (fault_held),
        .vcc_ge_on      (vcc_ge_on),
        .vcc_ge_on_m1   (vcc_ge_on_m1),
        .vcc_ge_restart (vcc_ge_restart),
        .above_active   (above_active),
        .state          (state)
    );

    vsup_outdec u_dec (
        .state     (state),
        .bus_ok    (bus_ok),
        .hv_src_en (hv_src_en),
        .supply_ok (supply_ok),
        .run       (run)
    );

    AST_SRC_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_src_en && run)); // R9

    AST_RUN_HAS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> supply_ok); // R3

    AST_RUN_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fault_held && !(uvlo_low_sel ? vcc_ge_off_red : vcc_ge_off_nom)) |=> !run); // R3

    AST_FAULT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fault_held) |=> (!run && supply_ok && !hv_src_en)); // R7

endmodule

// File: tb/sim_vsup_top.sv
// Bench for vsup_top: a vector walk followed by directed reset checks.
module sim_vsup_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_ok = 1'b0, light_load = 1'b0, fault_held = 1'b0;
    logic vcc_ge_on = 1'b0, vcc_ge_on_m1 = 1'b0, vcc_ge_off_nom = 1'b0;
    logic vcc_ge_off_red = 1'b0, vcc_ge_restart = 1'b0;
    logic hv_src_en, supply_ok, run, uvlo_low_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vsup_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .light_load(light_load),
        .fault_held(fault_held), .vcc_ge_on(vcc_ge_on), .vcc_ge_on_m1(vcc_ge_on_m1),
        .vcc_ge_off_nom(vcc_ge_off_nom), .vcc_ge_off_red(vcc_ge_off_red),
        .vcc_ge_restart(vcc_ge_restart), .hv_src_en(hv_src_en),
        .supply_ok(supply_ok), .run(run), .uvlo_low_sel(uvlo_low_sel)
    );

    // Input bits: bus, light, fault, on, on_m1, off_nom, off_red, restart.
    // Expected: src, ok, run, low.
    typedef struct packed {
        logic [7:0] stim;
        logic [3:0] exp;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'b1000_0001, 4'b1000, 8'd2},  // R2 charging with bus
        '{8'b1001_1111, 4'b0110, 8'd2},  // R2 turn-on reached
        '{8'b1101_1111, 4'b0111, 8'd5},  // R5 light load selects reduced
        '{8'b1100_1011, 4'b0111, 8'd3},  // R3 below nominal, above reduced: keeps running
        '{8'b1000_1011, 4'b0111, 8'd6},  // R6 load cleared but supply below nominal
        '{8'b1000_1111, 4'b0110, 8'd6},  // R6 both conditions: normal restored
        '{8'b1000_1011, 4'b0100, 8'd3},  // R3 below nominal: run stops, ok stays
        '{8'b1000_0001, 4'b0100, 8'd3},  // R3 ok held above restart
        '{8'b1000_0000, 4'b1000, 8'd4},  // R4 below restart, bus present
        '{8'b1001_1111, 4'b0110, 8'd2},  // R2 running again
        '{8'b0000_1011, 4'b0100, 8'd3},  // R3 bus lost, supply sags
        '{8'b0000_0000, 4'b0000, 8'd4},  // R4 no re-arm without bus
        '{8'b1000_0000, 4'b1000, 8'd4},  // R4 bus returns
        '{8'b1001_1111, 4'b0110, 8'd2},  // R2 running
        '{8'b1011_1111, 4'b0100, 8'd7},  // R7 fault enters hold
        '{8'b1010_1111, 4'b0100, 8'd7},  // R7 between levels: still hold
        '{8'b1010_0111, 4'b1100, 8'd7},  // R7 below on-minus-one: recharge
        '{8'b1010_1111, 4'b1100, 8'd7},  // R7 between levels: keep charging
        '{8'b1011_1111, 4'b0100, 8'd7},  // R7 turn-on: back to hold
        '{8'b0000_0011, 4'b0100, 8'd8},  // R8 fault released: drain
        '{8'b0000_0000, 4'b0000, 8'd4}   // R4 drained to charging, no bus
    };

    task automatic apply(input logic [7:0] s);
        {bus_ok, light_load, fault_held, vcc_ge_on, vcc_ge_on_m1,
         vcc_ge_off_nom, vcc_ge_off_red, vcc_ge_restart} = s;
    endtask

    task automatic check(input logic [3:0] e, input logic [7:0] tag, input int idx);
        logic [3:0] a;
        a = {hv_src_en, supply_ok, run, uvlo_low_sel};
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL R%0d step %0d: got %b expected %b", tag, idx, a, e);
        end
    endtask

    initial begin
        // R1: reset with bus absent, then with bus present.
        apply(8'b0000_0000);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(4'b0000, 8'd1, 100);
        apply(8'b1000_0000);
        @(negedge clk);
        check(4'b1000, 8'd1, 101);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].stim);
            @(negedge clk);
            check(VECS[i].exp, VECS[i].tag, i);
        end
        // R1: reset while running with reduced level restores the charging state.
        apply(8'b1001_1111);
        @(negedge clk);
        apply(8'b1101_1111);
        @(negedge clk);
        check(4'b0111, 8'd5, 200);
        rst_n = 1'b0;
        apply(8'b1000_1111);
        @(negedge clk);
        check(4'b1000, 8'd1, 201);
        rst_n = 1'b1;
        // R5: light load during charging still selects the reduced level.
        apply(8'b1100_0001);
        @(negedge clk);
        check(4'b1001, 8'd5, 202);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule